// File: doc/BRIEF.md
# Output Raster Phase Shift Controller

This block belongs to the output side of a two-channel split-screen display path. When two input sources run at different line phases, the seam where their pictures meet shows a broken line. The block removes that seam by delaying the start of output processing. On each output frame it adds a programmed number of lines to the delay. It stops once the write positions of the enabled channels line up with the read position.

At each output frame start strobe, the block compares the write line positions of the channels with the read line position. The main channel has its own enable. The secondary channel has an enable that only counts when the main enable is also set. If any enabled channel is out of line, the delay grows by the step, saturating at its largest value, and the busy flag is set. If every enabled channel is in line, the delay holds and the busy flag clears. With the main enable off, the delay is reloaded from the programmed base value. A progressive secondary channel is allowed a small gap, set by a threshold, before it counts as out of line.

All settings are sampled only at the frame start strobe.

Top module: `rsh_ctrl`

## Requirements
- R1: After reset, `delay_o` is 0 and `shift_busy_o` is 0.
- R2: Both outputs change only on the clock edge that samples `frame_start_i` high. Input changes between strobes have no effect on the outputs.
- R3: At a strobe with `shift_main_en_i`=0, `delay_o` loads `base_delay_i` and `shift_busy_o` goes to 0. This holds whatever the secondary enable and the line positions are.
- R4: At a strobe with the main enable set and `main_wr_line_i` != `rd_line_i`, `delay_o` grows by `step_i` (0 to 15 lines) and `shift_busy_o` goes to 1.
- R5: At a strobe with the main enable set and no enabled channel out of line, `delay_o` holds and `shift_busy_o` goes to 0. `base_delay_i` is ignored in this case.
- R6: The grown delay saturates at 2^LINE_W-1 and never wraps.
- R7: With both enables set and `sub_prog_i`=0, `sub_wr_line_i` != `rd_line_i` at a strobe counts as out of line. With `shift_sub_en_i`=0, the secondary position is ignored.
- R8: With both enables set and `sub_prog_i`=1, the secondary channel counts as out of line only when its line distance to the read position exceeds `prog_thr_i`.
- R9: Line distance is circular: with d = (write - read) mod 2^LINE_W, the distance is min(d, 2^LINE_W - d).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | One-cycle output frame start strobe |
| shift_main_en_i | input | 1 | Main channel shift enable |
| shift_sub_en_i | input | 1 | Secondary channel shift enable (needs main enable) |
| sub_prog_i | input | 1 | Secondary channel is progressive |
| step_i | input | STEP_W | Lines added per frame while shifting |
| prog_thr_i | input | THR_W | Allowed distance for a progressive secondary channel |
| base_delay_i | input | LINE_W | Programmed output start delay |
| main_wr_line_i | input | LINE_W | Main channel write line position |
| sub_wr_line_i | input | LINE_W | Secondary channel write line position |
| rd_line_i | input | LINE_W | Read line position |
| delay_o | output | LINE_W | Current output start delay in lines |
| shift_busy_o | output | 1 | Shift in progress |

## Verification
The bench sweeps every step value from 0 to 15 through runs of several out-of-line frames followed by an aligned frame. This separates a wrong increment from a failure to hold or to clear the busy flag. Base values close to the maximum drive the delay into saturation, which shows any wraparound. For a progressive secondary channel, signed offsets from -12 to +12 are swept against several thresholds, with the read position placed so that some offsets cross the counter wrap. This checks the strict comparison, the circular distance and the use of the secondary enable. Separate patterns change the settings between strobes and then check that the outputs do not move.

// File: rtl/rsh_pkg.sv
package rsh_pkg;
  typedef enum logic [1:0] {
    RSH_LOAD = 2'd0,
    RSH_GROW = 2'd1,
    RSH_HOLD = 2'd2
  } rsh_act_e;
endpackage

// File: rtl/rsh_gap_detect.sv
module rsh_gap_detect #(
  parameter int LINE_W = 11,
  parameter int THR_W  = 7
) (
  input  logic              main_en_i,
  input  logic              sub_en_i,
  input  logic              sub_prog_i,
  input  logic [THR_W-1:0]  thr_i,
  input  logic [LINE_W-1:0] main_wr_i,
  input  logic [LINE_W-1:0] sub_wr_i,
  input  logic [LINE_W-1:0] rd_i,
  output logic              misalign_o
);
  localparam int CW = (LINE_W > THR_W) ? LINE_W : THR_W;

  logic [LINE_W-1:0] diff_main, diff_sub, dist_sub;
  logic [CW-1:0]     dist_x, thr_x;
  logic              main_off, sub_off;

  always_comb begin
    diff_main = main_wr_i - rd_i;
    diff_sub  = sub_wr_i - rd_i;
    // circular distance: take the shorter way round (R9)
    dist_sub  = diff_sub[LINE_W-1] ? (~diff_sub + 1'b1) : diff_sub;
    dist_x    = CW'(dist_sub);
    thr_x     = CW'(thr_i);
    main_off  = |diff_main;
    if (sub_prog_i) sub_off = dist_x > thr_x;
    else            sub_off = |diff_sub;
    misalign_o = main_en_i & (main_off | (sub_en_i & sub_off));
  end
endmodule

// File: rtl/rsh_step_acc.sv
module rsh_step_acc
  import rsh_pkg::*;
#(
  parameter int LINE_W = 11,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic              main_en_i,
  input  logic              misalign_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [LINE_W-1:0] base_i,
  output logic [LINE_W-1:0] delay_o,
  output logic              busy_o
);
  logic [LINE_W-1:0] delay_q, delay_d, grown;
  logic [LINE_W:0]   sum;
  logic              busy_q, busy_d;
  rsh_act_e          act;

  always_comb begin
    if (!main_en_i)      act = RSH_LOAD;
    else if (misalign_i) act = RSH_GROW;
    else                 act = RSH_HOLD;
    sum   = {1'b0, delay_q} + (LINE_W+1)'(step_i);
    grown = sum[LINE_W] ? {LINE_W{1'b1}} : sum[LINE_W-1:0];
    case (act)
      RSH_LOAD: begin delay_d = base_i;  busy_d = 1'b0; end
      RSH_GROW: begin delay_d = grown;   busy_d = 1'b1; end
      default:  begin delay_d = delay_q; busy_d = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delay_q <= '0;
      busy_q  <= 1'b0;
    end else if (frame_start_i) begin
      delay_q <= delay_d;
      busy_q  <= busy_d;
    end
  end

  assign delay_o = delay_q;
  assign busy_o  = busy_q;

  // R2
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start_i |=> $stable(delay_q) && $stable(busy_q));
  // R3
  off_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i && !main_en_i |=> delay_q == $past(base_i) && !busy_q);
  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i && main_en_i && misalign_i |=> busy_q && delay_q >= $past(delay_q));
  // R5
  aligned_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i && main_en_i && !misalign_i |=> $stable(delay_q) && !busy_q);
endmodule

// File: rtl/rsh_ctrl.sv
module rsh_ctrl #(
  parameter int LINE_W = 11,
  parameter int STEP_W = 4,
  parameter int THR_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic              shift_main_en_i,
  input  logic              shift_sub_en_i,
  input  logic              sub_prog_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [THR_W-1:0]  prog_thr_i,
  input  logic [LINE_W-1:0] base_delay_i,
  input  logic [LINE_W-1:0] main_wr_line_i,
  input  logic [LINE_W-1:0] sub_wr_line_i,
  input  logic [LINE_W-1:0] rd_line_i,
  output logic [LINE_W-1:0] delay_o,
  output logic              shift_busy_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       misalign;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rsh_gap_detect #(.LINE_W(LINE_W), .THR_W(THR_W)) u_gap (
    .main_en_i  (shift_main_en_i),
    .sub_en_i   (shift_sub_en_i),
    .sub_prog_i (sub_prog_i),
    .thr_i      (prog_thr_i),
    .main_wr_i  (main_wr_line_i),
    .sub_wr_i   (sub_wr_line_i),
    .rd_i       (rd_line_i),
    .misalign_o (misalign)
  );

  rsh_step_acc #(.LINE_W(LINE_W), .STEP_W(STEP_W)) u_acc (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .frame_start_i (frame_start_i),
    .main_en_i     (shift_main_en_i),
    .misalign_i    (misalign),
    .step_i        (step_i),
    .base_i        (base_delay_i),
    .delay_o       (delay_o),
    .busy_o        (shift_busy_o)
  );
endmodule

// File: tb/sim_rsh_ctrl.sv
module sim_rsh_ctrl;
  localparam int LW = 6;
  localparam int SW = 4;
  localparam int TW = 7;
  localparam int MAXD = (1 << LW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic fs, me, se, sp;
  logic [SW-1:0] st;
  logic [TW-1:0] thr;
  logic [LW-1:0] base, mw, sw, rd;
  logic [LW-1:0] delay;
  logic busy;

  int n_tot = 0;
  int n_bad = 0;
  int exp_d = 0;
  int exp_b = 0;

  always #5 clk = ~clk;

  rsh_ctrl #(.LINE_W(LW), .STEP_W(SW), .THR_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_start_i(fs),
    .shift_main_en_i(me), .shift_sub_en_i(se), .sub_prog_i(sp),
    .step_i(st), .prog_thr_i(thr), .base_delay_i(base),
    .main_wr_line_i(mw), .sub_wr_line_i(sw), .rd_line_i(rd),
    .delay_o(delay), .shift_busy_o(busy)
  );

  task automatic chk(input string r, input int act, input int exp);
    n_tot++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int cdist(input int wr, input int rdv);
    int d;
    d = (wr - rdv) & MAXD;
    return (d <= (MAXD + 1) / 2) ? d : (MAXD + 1 - d);
  endfunction

  task automatic frame(input string r);
    bit mis;
    mis = (cdist(mw, rd) != 0) ||
          (se && (sp ? (cdist(sw, rd) > int'(thr)) : (cdist(sw, rd) != 0)));
    if (!me) begin
      exp_d = base; exp_b = 0;
    end else if (mis) begin
      exp_d = (exp_d + st > MAXD) ? MAXD : exp_d + st; exp_b = 1;
    end else begin
      exp_b = 0;
    end
    fs = 1'b1;
    @(negedge clk);
    fs = 1'b0;
    @(negedge clk);
    chk({r, " delay"}, delay, exp_d);
    chk({r, " busy"}, busy, exp_b);
  endtask

  function automatic logic [LW-1:0] at(input int off);
    return LW'((int'(rd) + off) & MAXD);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fs = 0; me = 0; se = 0; sp = 0;
    st = 4; thr = 60; base = 0; mw = 0; sw = 0; rd = 20;
    repeat (3) @(negedge clk);
    chk("R1 delay", delay, 0);
    chk("R1 busy", busy, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 delay after release", delay, 0);

    // R3: main off loads base regardless of sub and gaps
    se = 1; mw = at(5); sw = at(-3); base = 13; frame("R3");
    base = 40; frame("R3");

    // R2: inputs change without strobe
    me = 1; st = 7; base = 2;
    repeat (5) @(negedge clk);
    chk("R2 delay", delay, 40);
    chk("R2 busy", busy, 0);
    se = 0;

    // R4/R5: step sweep
    for (int s = 0; s < 16; s++) begin
      me = 0; base = 5; mw = rd; frame("R3");
      me = 1; st = SW'(s);
      for (int k = 0; k < 3; k++) begin
        mw = at((s % 5) + 1 + k); frame("R4");
      end
      mw = rd; frame("R5");
      base = 9; frame("R5 base ignored");
    end

    // R2: mid-shift changes without strobe
    me = 0; base = 10; frame("R3");
    me = 1; st = 3; mw = at(2); frame("R4");
    mw = rd; st = 9; me = 0;
    repeat (4) @(negedge clk);
    chk("R2 delay mid", delay, 13);
    chk("R2 busy mid", busy, 1);
    me = 1;

    // R6: saturation
    me = 0; base = 60; frame("R3");
    me = 1; st = 4; mw = at(1);
    for (int k = 0; k < 3; k++) frame("R6");
    me = 0; base = 62; frame("R3");
    me = 1; st = 15; frame("R6");
    frame("R6");

    // R7: secondary enable, interlaced
    me = 0; base = 8; mw = rd; frame("R3");
    me = 1; se = 1; sp = 0; st = 2; sw = at(-3); frame("R7 sub gap");
    frame("R7 sub gap again");
    se = 0; frame("R7 sub disabled");
    se = 1; sw = rd; frame("R7 sub aligned");

    // R8/R9: progressive threshold sweep across the wrap
    rd = 58; sp = 1; st = 1;
    for (int ti = 0; ti < 3; ti++) begin
      thr = (ti == 0) ? 7'd0 : (ti == 1) ? 7'd3 : 7'd10;
      for (int off = -12; off <= 12; off++) begin
        me = 0; se = 1; base = 20; mw = rd; frame("R3");
        me = 1; sw = at(off); frame("R8 R9");
      end
    end

    // R9: half-way distance and wrap
    thr = 31; me = 0; base = 0; frame("R3");
    me = 1; sw = at(32); frame("R9 half");
    thr = 2; rd = 62; sw = 6'd1; frame("R9 wrap");

    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule